// File: doc/BRIEF.md
# Memory-Map Address Decoder

This block sits beside a small processor core and turns each 16-bit bus address into a choice of responder: the control-register block, the internal RAM, the main program ROM, the bootstrap ROM, or the external bus. For the chosen responder it also gives the offset of the address inside that resource, so the memory arrays can be indexed directly. The decode is combinational from the address and strobes to the selects. The only state is a small set of control registers that live inside the register block and are written through that same bus.

Two operating-mode strap pins are sampled while reset is held. They decide where the main ROM sits, whether the bootstrap ROM exists, and whether unclaimed addresses go out to the external bus. A relocation register moves the RAM and the register block to any 4 KB page at run time, but only during a short window after reset. A mode bit lets software that started in single-chip mode open the external bus while the ROM stays at the top of memory. A ROM-enable bit takes the main ROM out of the map. Where regions overlap, a fixed priority settles which one answers.

The block carries no data stream. Address, strobes and selects are plain control pins with no valid/ready handshake and no back-pressure: every access is decoded in the cycle it is presented.

Top module: `mem_map_decoder`

## Requirements
- R1: After reset the relocation register reads 0x00, the priority register reads 0x00 and the configuration register reads 0x02. So the registers sit at 0x0000–0x003F, the RAM at 0x0040–0x00FF, and the main ROM is enabled.
- R2: The register block spans 64 bytes from page*0x1000 of its page. It selects chip_sel[0], and the offset is address minus that base.
- R3: The RAM spans 192 bytes from page*0x1000+0x40 of its page. It selects chip_sel[1], and the offset is address minus that base (0..191).
- R4: The relocation register is at register offset 0x3D, with the RAM page in bits 7:4 and the register page in bits 3:0. A write takes effect only if fewer than 64 accesses (cycles with rd_en or wr_en) have completed since reset, so the 64th access may write and the 65th may not. Reads return the current value at any time.
- R5: mode_strap is sampled while rst_n is low: 00 bootstrap, 01 special test, 10 single-chip, 11 expanded. Changes on the pins after reset have no effect.
- R6: The main ROM (4 KB, chip_sel[3], offset = address[11:0]) decodes at 0xF000–0xFFFF. When the strap was expanded, it decodes at 0x7000–0x7FFF instead.
- R7: Bit 5 of the priority register (offset 0x3C) is the expand bit. Setting it enables external access for unclaimed addresses, and the ROM stays at 0xF000 when the strap was single-chip.
- R8: Bit 1 of the configuration register (offset 0x3F) enables the main ROM and resets to 1. While it is 0, no address selects the ROM.
- R9: The bootstrap ROM (chip_sel[2]) decodes at 0xBF40–0xBFFF with offset address−0xBF40, and only when the strap was bootstrap.
- R10: When regions overlap, priority is registers, then RAM, then bootstrap ROM, then main ROM, then external.
- R11: An access no internal region claims raises ext_access with local_offset = address. This happens only in test or expanded mode, or when the expand bit is set. Otherwise nothing is selected and the offset is 0.
- R12: At most one of chip_sel and ext_access is active. With rd_en and wr_en both low, all of them are low.
- R13: rdata gives the addressed control register during a read that selects the register block. It is 0 for other register offsets and for any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps sampled while low |
| mode_strap | input | 2 | Operating-mode straps |
| addr | input | 16 | Bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data for control registers |
| rdata | output | 8 | Read data from control registers |
| chip_sel | output | 4 | One-hot select: 0 registers, 1 RAM, 2 bootstrap ROM, 3 main ROM |
| ext_access | output | 1 | External bus access |
| local_offset | output | 16 | Offset within the selected resource |

## Verification
On every cycle the assertions check the following. At most one responder is active, and none is active when there is no access. The bootstrap ROM answers only in bootstrap mode, and the main ROM never answers while it is disabled. The external flag appears only in modes that allow it. RAM offsets stay in range. The latched mode and, once the access count passes the window, the relocation value never change. Only the bench's scenarios can show that every address lands on the right region with the right offset. Its full 64K sweeps under each strap, page choice and enable setting compare against an arithmetic model. The scenarios also show the exact 64th/65th access boundary of the relocation window and the register read-back values.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int PAGE_W     = 4;
  localparam int NUM_REGION = 4;
  localparam int REG_OFS_W  = 6;

  typedef enum logic [1:0] {
    MODE_BOOT     = 2'b00,
    MODE_TEST     = 2'b01,
    MODE_SINGLE   = 2'b10,
    MODE_EXPANDED = 2'b11
  } op_mode_e;

  // region index doubles as priority rank: lower index wins
  localparam int RGN_REG  = 0;
  localparam int RGN_RAM  = 1;
  localparam int RGN_BOOT = 2;
  localparam int RGN_ROM  = 3;

  localparam logic [REG_OFS_W-1:0] OFS_PRIO   = 6'h3C;
  localparam logic [REG_OFS_W-1:0] OFS_RELOC  = 6'h3D;
  localparam logic [REG_OFS_W-1:0] OFS_CONFIG = 6'h3F;

  localparam int PRIO_EXP_BIT  = 5;
  localparam int CFG_ROMEN_BIT = 1;
endpackage

// File: rtl/mmd_region_match.sv
module mmd_region_match
  import mmd_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   span,
  input  logic          enable,
  output logic          hit,
  output logic [AW-1:0] offset
);
  logic [AW:0] diff;

  always_comb begin
    diff   = {1'b0, addr} - {1'b0, base};
    hit    = enable && (addr >= base) && (diff < span);
    offset = diff[AW-1:0];
  end
endmodule

// File: rtl/mmd_priority.sv
module mmd_priority
  import mmd_pkg::*;
#(
  parameter int N  = NUM_REGION,
  parameter int AW = ADDR_W
) (
  input  logic [N-1:0]         hits,
  input  logic [N-1:0][AW-1:0] offsets,
  input  logic [AW-1:0]        addr,
  input  logic                 access,
  input  logic                 ext_allowed,
  output logic [N-1:0]         sel,
  output logic                 ext,
  output logic [AW-1:0]        offset
);
  logic found;

  always_comb begin
    sel    = '0;
    offset = '0;
    ext    = 1'b0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && hits[i]) begin
        sel[i] = 1'b1;
        offset = offsets[i];
        found  = 1'b1;
      end
    end
    if (!access) begin
      sel    = '0;
      offset = '0;
    end else if (!found && ext_allowed) begin
      ext    = 1'b1;
      offset = addr;
    end
  end
endmodule

// File: rtl/mmd_ctrl_regs.sv
module mmd_ctrl_regs
  import mmd_pkg::*;
#(
  parameter int INIT_WINDOW = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_strap,
  input  logic                 access,
  input  logic                 reg_wr,
  input  logic [REG_OFS_W-1:0] reg_ofs,
  input  logic [DATA_W-1:0]    wdata,
  output op_mode_e             op_mode,
  output logic [PAGE_W-1:0]    ram_page,
  output logic [PAGE_W-1:0]    reg_page,
  output logic                 exp_req,
  output logic                 rom_en,
  output logic [DATA_W-1:0]    reg_rdata
);
  localparam int CNT_W = $clog2(INIT_WINDOW + 1);
  localparam logic [CNT_W-1:0] WIN_LIMIT = CNT_W'(INIT_WINDOW);

  logic [CNT_W-1:0] acc_cnt;
  logic             window_open;

  // straps are captured while reset is held and frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) op_mode <= op_mode_e'(mode_strap);
  end

  assign window_open = (acc_cnt < WIN_LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
    end else if (access && window_open) begin
      acc_cnt <= acc_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_page <= '0;
      reg_page <= '0;
      exp_req  <= 1'b0;
      rom_en   <= 1'b1;
    end else if (reg_wr) begin
      unique case (reg_ofs)
        OFS_RELOC: begin
          if (window_open) begin
            ram_page <= wdata[DATA_W-1 -: PAGE_W];
            reg_page <= wdata[PAGE_W-1:0];
          end
        end
        OFS_PRIO:   exp_req <= wdata[PRIO_EXP_BIT];
        OFS_CONFIG: rom_en  <= wdata[CFG_ROMEN_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_ofs)
      OFS_RELOC:  reg_rdata = {ram_page, reg_page};
      OFS_PRIO:   reg_rdata[PRIO_EXP_BIT] = exp_req;
      OFS_CONFIG: reg_rdata[CFG_ROMEN_BIT] = rom_en;
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter int                INIT_WINDOW  = 64,
  parameter int                REG_SPAN     = 64,
  parameter int                RAM_SPAN     = 192,
  parameter int                BOOT_SPAN    = 192,
  parameter int                ROM_SPAN     = 4096,
  parameter logic [ADDR_W-1:0] RAM_LO       = 16'h0040,
  parameter logic [ADDR_W-1:0] BOOT_BASE    = 16'hBF40,
  parameter logic [ADDR_W-1:0] ROM_STD_BASE = 16'hF000,
  parameter logic [ADDR_W-1:0] ROM_ALT_BASE = 16'h7000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_strap,
  input  logic [15:0]       addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [3:0]        chip_sel,
  output logic              ext_access,
  output logic [15:0]       local_offset
);
  localparam int PAGE_SHIFT = ADDR_W - PAGE_W;

  op_mode_e                          op_mode;
  logic [PAGE_W-1:0]                 ram_page;
  logic [PAGE_W-1:0]                 reg_page;
  logic                              exp_req;
  logic                              rom_en;
  logic [DATA_W-1:0]                 reg_rdata;
  logic                              access;
  logic                              ext_allowed;
  logic [NUM_REGION-1:0][ADDR_W-1:0] rgn_base;
  logic [NUM_REGION-1:0][ADDR_W:0]   rgn_span;
  logic [NUM_REGION-1:0]             rgn_en;
  logic [NUM_REGION-1:0]             rgn_hit;
  logic [NUM_REGION-1:0][ADDR_W-1:0] rgn_ofs;

  assign access = rd_en | wr_en;

  mmd_ctrl_regs #(.INIT_WINDOW(INIT_WINDOW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_strap (mode_strap),
    .access     (access),
    .reg_wr     (wr_en & chip_sel[RGN_REG]),
    .reg_ofs    (local_offset[REG_OFS_W-1:0]),
    .wdata      (wdata),
    .op_mode    (op_mode),
    .ram_page   (ram_page),
    .reg_page   (reg_page),
    .exp_req    (exp_req),
    .rom_en     (rom_en),
    .reg_rdata  (reg_rdata)
  );

  always_comb begin
    rgn_base[RGN_REG]  = {reg_page, {PAGE_SHIFT{1'b0}}};
    rgn_span[RGN_REG]  = (ADDR_W+1)'(REG_SPAN);
    rgn_en[RGN_REG]    = 1'b1;

    rgn_base[RGN_RAM]  = {ram_page, RAM_LO[PAGE_SHIFT-1:0]};
    rgn_span[RGN_RAM]  = (ADDR_W+1)'(RAM_SPAN);
    rgn_en[RGN_RAM]    = 1'b1;

    rgn_base[RGN_BOOT] = BOOT_BASE;
    rgn_span[RGN_BOOT] = (ADDR_W+1)'(BOOT_SPAN);
    rgn_en[RGN_BOOT]   = (op_mode == MODE_BOOT);

    rgn_base[RGN_ROM]  = (op_mode == MODE_EXPANDED) ? ROM_ALT_BASE : ROM_STD_BASE;
    rgn_span[RGN_ROM]  = (ADDR_W+1)'(ROM_SPAN);
    rgn_en[RGN_ROM]    = rom_en;
  end

  for (genvar g = 0; g < NUM_REGION; g++) begin : g_match
    mmd_region_match #(.AW(ADDR_W)) u_match (
      .addr   (addr),
      .base   (rgn_base[g]),
      .span   (rgn_span[g]),
      .enable (rgn_en[g]),
      .hit    (rgn_hit[g]),
      .offset (rgn_ofs[g])
    );
  end

  assign ext_allowed = (op_mode == MODE_TEST) || (op_mode == MODE_EXPANDED) || exp_req;

  mmd_priority #(.N(NUM_REGION), .AW(ADDR_W)) u_prio (
    .hits        (rgn_hit),
    .offsets     (rgn_ofs),
    .addr        (addr),
    .access      (access),
    .ext_allowed (ext_allowed),
    .sel         (chip_sel),
    .ext         (ext_access),
    .offset      (local_offset)
  );

  assign rdata = (rd_en && chip_sel[RGN_REG]) ? reg_rdata : '0;
endmodule

// File: rtl/mmd_checker.sv
module mmd_checker
  import mmd_pkg::*;
#(
  parameter int INIT_WINDOW = 64,
  parameter int RAM_SPAN    = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [3:0]  chip_sel,
  input  logic        ext_access,
  input  logic [15:0] local_offset,
  input  logic [1:0]  op_mode,
  input  logic        exp_req,
  input  logic        rom_en,
  input  logic [7:0]  reloc
);
  localparam int CW = $clog2(INIT_WINDOW + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if ((rd_en | wr_en) && (seen < CW'(INIT_WINDOW))) seen <= seen + 1'b1;
  end

  a_r12_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_sel, ext_access}));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en | wr_en) |-> (chip_sel == 4'b0 && !ext_access));

  a_r9_boot_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel[RGN_BOOT] |-> (op_mode == MODE_BOOT));

  a_r8_rom_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_en |-> !chip_sel[RGN_ROM]);

  a_r11_ext_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ext_access |-> (op_mode == MODE_TEST || op_mode == MODE_EXPANDED || exp_req));

  a_r3_ram_offset: assert property (@(posedge clk) disable iff (!rst_n)
    chip_sel[RGN_RAM] |-> (local_offset < 16'(RAM_SPAN)));

  a_r5_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(op_mode));

  a_r4_reloc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= CW'(INIT_WINDOW)) |=> $stable(reloc));
endmodule

bind mem_map_decoder mmd_checker #(.INIT_WINDOW(INIT_WINDOW), .RAM_SPAN(RAM_SPAN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .chip_sel     (chip_sel),
  .ext_access   (ext_access),
  .local_offset (local_offset),
  .op_mode      (op_mode),
  .exp_req      (exp_req),
  .rom_en       (rom_en),
  .reloc        ({ram_page, reg_page})
);

// File: tb/tb_mem_map_decoder.sv
module tb_mem_map_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_strap = 2'b10;
  logic [15:0] addr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  chip_sel;
  logic        ext_access;
  logic [15:0] local_offset;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mem_map_decoder dut (
    .clk(clk), .rst_n(rst_n), .mode_strap(mode_strap), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .chip_sel(chip_sel), .ext_access(ext_access), .local_offset(local_offset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // arithmetic model of the map; sel index 0 reg,1 ram,2 boot,3 rom
  task automatic model(input int a, input int strap, input int rampg, input int regpg,
                       input int xb, input int romon,
                       output int sel, output int ext, output int ofs, output string tag);
    int rb, mb, ob;
    rb = regpg * 4096;
    mb = rampg * 4096 + 64;
    ob = (strap == 3) ? 'h7000 : 'hF000;
    sel = 0; ext = 0; ofs = 0; tag = "R11";
    if (a >= rb && a < rb + 64) begin sel = 1; ofs = a - rb; tag = "R2"; end
    else if (a >= mb && a < mb + 192) begin sel = 2; ofs = a - mb; tag = "R3"; end
    else if (strap == 0 && a >= 'hBF40 && a <= 'hBFFF) begin sel = 4; ofs = a - 'hBF40; tag = "R9"; end
    else if (romon != 0 && a >= ob && a < ob + 4096) begin sel = 8; ofs = a - ob; tag = "R6"; end
    else if (strap == 1 || strap == 3 || xb != 0) begin ext = 1; ofs = a; end
  endtask

  task automatic do_reset(input logic [1:0] strap);
    @(negedge clk);
    rst_n = 1'b0; mode_strap = strap; rd_en = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one bus access: driven at negedge, counted at the next posedge
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2;
    check(rdata == exp, tag, $sformatf("read 0x%04h", a), rdata, exp);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic point(input logic [15:0] a, input int esel, input int eext,
                       input int eofs, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #2;
    check(chip_sel == esel[3:0] && ext_access == eext[0] && local_offset == eofs[15:0],
          tag, $sformatf("decode 0x%04h sel/ext/ofs", a),
          {chip_sel, 3'b0, ext_access, local_offset}, (esel << 20) | (eext << 16) | eofs);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic sweep(input int strap, input int rampg, input int regpg,
                       input int xb, input int romon);
    int bad = 0;
    int fa = 0, fs = 0, fe = 0, fo = 0, gs = 0, ge = 0, go = 0;
    string ft = "";
    @(negedge clk);
    for (int a = 0; a < 65536; a++) begin
      int es, ee, eo;
      string tg;
      addr = a[15:0]; rd_en = 1'b1;
      #1;
      model(a, strap, rampg, regpg, xb, romon, es, ee, eo, tg);
      if (chip_sel != es[3:0] || ext_access != ee[0] || local_offset != eo[15:0]) begin
        if (bad == 0) begin
          fa = a; fs = es; fe = ee; fo = eo; ft = tg;
          gs = chip_sel; ge = ext_access; go = local_offset;
        end
        bad++;
      end
      #1;
    end
    rd_en = 1'b0;
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s R10 sweep strap=%0d at 0x%04h: actual sel=%0h ext=%0d ofs=0x%0h expected sel=%0h ext=%0d ofs=0x%0h",
               ft, strap, fa, gs, ge, go, fs, fe, fo);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    // single-chip, reset state (R1, R13, R12)
    do_reset(2'b10);
    @(negedge clk); #2;
    check(chip_sel == 4'b0 && !ext_access, "R12", "idle selects", {chip_sel, ext_access}, 0);
    check(rdata == 8'h00, "R13", "idle rdata", rdata, 0);
    bus_read(16'h003D, 8'h00, "R1");   // access 1
    bus_read(16'h003C, 8'h00, "R1");   // 2
    bus_read(16'h003F, 8'h02, "R1");   // 3
    bus_read(16'h0000, 8'h00, "R13");  // 4
    point(16'h0040, 2, 0, 0, "R1");    // 5
    point(16'hF000, 8, 0, 0, "R6");    // 6
    point(16'h8000, 0, 0, 0, "R11");   // 7
    // fill up to 63 accesses, then the 64th write is accepted (R4)
    for (int i = 7; i < 63; i++) bus_read(16'h0001, 8'h00, "R13");
    bus_write(16'h003D, 8'h11);        // 64th
    bus_write(16'h103D, 8'h22);        // 65th, ignored
    bus_read(16'h103D, 8'h11, "R4");
    point(16'h1005, 1, 0, 5, "R2");
    point(16'h10FF, 2, 0, 191, "R3");
    sweep(2, 1, 1, 0, 1);
    // expand bit in single-chip: ROM stays high, external opens (R7)
    bus_write(16'h103C, 8'h20);
    bus_read(16'h103C, 8'h20, "R7");
    point(16'hF123, 8, 0, 'h123, "R7");
    point(16'h7000, 0, 1, 'h7000, "R7");
    sweep(2, 1, 1, 1, 1);
    // ROM disable (R8)
    bus_write(16'h103F, 8'h00);
    bus_read(16'h103F, 8'h00, "R8");
    point(16'hF000, 0, 1, 'hF000, "R8");
    sweep(2, 1, 1, 1, 0);

    // expanded strap: ROM low, RAM overlaps ROM (R6, R10)
    do_reset(2'b11);
    bus_write(16'h003D, 8'h7F);
    point(16'h7040, 2, 0, 0, "R10");
    point(16'h7000, 8, 0, 0, "R6");
    point(16'hF010, 1, 0, 'h10, "R2");
    sweep(3, 7, 15, 0, 1);

    // bootstrap strap (R9)
    do_reset(2'b00);
    bus_write(16'h003D, 8'hBB);
    point(16'hBF40, 4, 0, 0, "R9");
    point(16'hBFFF, 4, 0, 191, "R9");
    point(16'hBF3F, 0, 0, 0, "R11");
    sweep(0, 11, 11, 0, 1);

    // test strap: registers and RAM over ROM; straps frozen (R5, R10)
    do_reset(2'b01);
    bus_write(16'h003D, 8'hFF);
    point(16'hF03F, 1, 0, 'h3F, "R10");
    point(16'hF040, 2, 0, 0, "R10");
    point(16'hF100, 8, 0, 'h100, "R6");
    mode_strap = 2'b00;
    point(16'hBF40, 0, 1, 'hBF40, "R5");
    sweep(1, 15, 15, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule